// File: doc/BRIEF.md
# Saturated-Series Multi-Scroll Chaos Generator

This block integrates a three-state jerk-type chaotic system in fixed-point arithmetic with a Forward Euler step. It runs without stopping once started. Two of the states follow simple integrator chains. The third state is driven by a linear feedback term plus a scaled nonlinearity f(x). That nonlinearity is a staircase: a set of flat saturation levels, with neighbouring levels joined by straight ramps. Adding more levels and breakpoints adds more scrolls to the attractor.

Every arithmetic operation sits in its own registered stage. The longest chain, which computes the third state, spans eight clocks. An iteration sequencer therefore holds the state registers constant for an eight-clock window. At the end of the window it writes back the three freshly computed values and raises a one-clock strobe.

A start pulse loads caller-supplied initial conditions and restarts the window. The step size, the four coefficients, the breakpoint table and the level table are plain inputs and are expected to stay static during a run.

Top module: `sscroll_gen`

## Requirements
- R1: After reset, x, y and z read zero and the strobe stays low. The strobe remains low, and the state remains zero, for as long as no start pulse has been seen.
- R2: A start pulse loads the x, y and z initial-condition inputs into the state. The loaded values appear on the outputs in the clock after the pulse.
- R3: While running, the strobe is high for exactly one clock in every 8 clocks. The first strobe comes 8 clocks after the start pulse is sampled. x, y and z change only in the cycle the strobe goes high (or on a start).
- R4: On each commit, the new x equals x + h·y.
- R5: On each commit, the new y equals y + h·z.
- R6: On each commit, the new z equals z + h·(d1·f(x) − a·x − b·y − c·z). Every term uses the state from before the commit, and additions wrap at the word width.
- R7: The breakpoint table has 2(n−1) entries, ascending from index 0 and packed with entry 0 in the low word. The level table has n entries, ascending from the bottom level, also packed with entry 0 in the low word. Below breakpoint 0, f(x) equals level 0. Above the last breakpoint, f(x) equals the top level. Between breakpoints 2r−1 and 2r (exclusive), f(x) equals level r. All comparisons are signed.
- R8: Ramp r covers breakpoints 2r to 2r+1, both ends inclusive. On that ramp, f(x) = mean + ((level r+1 − level r) · (x − mid)) / gap. Here mid and mean are the floored halves of the breakpoint sum and of the level sum. The gap is the breakpoint difference. The full-width product is divided with truncation toward zero. A zero gap gives f(x) = mean.
- R9: Every multiplication forms the full signed double-width product and shifts it right arithmetically by the fraction width (29 by default, so 1.0 is 2^29). It keeps the low word, which rounds toward minus infinity. For example, 0.5 times −1 LSB gives −1 LSB.
- R10: A start pulse in the middle of a window overrides the pending commit. It reloads the initial conditions, and the next strobe comes a full 8 clocks later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load initial conditions and (re)start iterating |
| x0_i | input | W | Initial x, signed fixed point |
| y0_i | input | W | Initial y, signed fixed point |
| z0_i | input | W | Initial z, signed fixed point |
| h_i | input | W | Euler step size |
| a_i | input | W | Coefficient on x in the z update |
| b_i | input | W | Coefficient on y in the z update |
| c_i | input | W | Coefficient on z in the z update |
| d1_i | input | W | Gain on f(x) in the z update |
| brk_i | input | 2(NLVL−1)·W | Breakpoint table, entry 0 in the low word |
| lvl_i | input | NLVL·W | Saturation level table, entry 0 in the low word |
| x_o | output | W | Current x state |
| y_o | output | W | Current y state |
| z_o | output | W | Current z state |
| step_o | output | 1 | High for one clock after each committed iteration |

## Verification
The hardest part to reach from the ports is each individual region of the staircase. In a normal chaotic run, x rarely lands exactly on a breakpoint or inside the very narrow ramp. To get there, the bench uses a probe configuration: a, b and c are zero, d1 and h are 1.0, and y and z start at zero. In that configuration the first committed z is exactly f(x0), so every region can be reached directly by choosing x0. This includes both breakpoint ends, one LSB outside a ramp, and a table with a zero-width ramp. A bit-exact integer model then follows several hundred iterations of the default two-scroll run and a restart that lands mid-window.

// File: rtl/sscroll_pkg.sv
package sscroll_pkg;
  // Clocks per Euler iteration: the registered depth of the z update chain.
  localparam int unsigned ITER_CLKS = 8;
endpackage

// File: rtl/sscroll_mul.sv
// Registered fixed-point multiplier: full product, aligned by FRAC, low word kept.
module sscroll_mul #(
  parameter int W    = 32,
  parameter int FRAC = 29
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic signed [W-1:0] op_a,
  input  logic signed [W-1:0] op_b,
  output logic signed [W-1:0] prod_o
);
  localparam int PW = 2 * W;

  logic signed [PW-1:0] aw, bw;
  logic signed [W-1:0]  prod_d;

  assign aw     = op_a;
  assign bw     = op_b;
  assign prod_d = W'((aw * bw) >>> FRAC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prod_o <= '0;
    else        prod_o <= prod_d;
  end
endmodule

// File: rtl/sscroll_pwl.sv
// Four-stage staircase nonlinearity: select segment, product, divide, add mean.
module sscroll_pwl #(
  parameter int W    = 32,
  parameter int NLVL = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic signed [W-1:0]        x_i,
  input  logic [2*(NLVL-1)*W-1:0]    brk_i,
  input  logic [NLVL*W-1:0]          lvl_i,
  output logic signed [W-1:0]        f_o
);
  localparam int NRAMP = NLVL - 1;
  localparam int NBRK  = 2 * NRAMP;
  localparam int PW    = 2 * W;

  logic signed [W-1:0] brk [NBRK];
  logic signed [W-1:0] lvl [NLVL];

  for (genvar gb = 0; gb < NBRK; gb++) begin : g_brk
    assign brk[gb] = brk_i[gb*W +: W];
  end
  for (genvar gl = 0; gl < NLVL; gl++) begin : g_lvl
    assign lvl[gl] = lvl_i[gl*W +: W];
  end

  // Stage 1 selection
  logic                ramp_d;
  logic signed [W-1:0] flat_d, bl, bh, kl, kh;
  logic signed [W:0]   bsum, ksum;
  logic signed [W-1:0] mid_d, mean_d, gap_d, diff_d, dx_d;

  always_comb begin
    flat_d = lvl[0];
    ramp_d = 1'b0;
    bl     = brk[0];
    bh     = brk[1];
    kl     = lvl[0];
    kh     = lvl[1];
    for (int r = 0; r < NRAMP; r++) begin
      if (x_i >= brk[2*r]) flat_d = lvl[r+1];
      if ((x_i >= brk[2*r]) && (x_i <= brk[2*r+1])) begin
        ramp_d = 1'b1;
        bl     = brk[2*r];
        bh     = brk[2*r+1];
        kl     = lvl[r];
        kh     = lvl[r+1];
      end
    end
  end

  assign bsum   = {bl[W-1], bl} + {bh[W-1], bh};
  assign ksum   = {kl[W-1], kl} + {kh[W-1], kh};
  assign mid_d  = W'(bsum >>> 1);
  assign mean_d = W'(ksum >>> 1);
  assign gap_d  = bh - bl;
  assign diff_d = kh - kl;
  assign dx_d   = x_i - mid_d;

  logic                ramp1_q, ramp2_q, ramp3_q;
  logic signed [W-1:0] flat1_q, flat2_q, flat3_q;
  logic signed [W-1:0] mean1_q, mean2_q, mean3_q;
  logic signed [W-1:0] gap1_q, gap2_q, diff1_q, dx1_q, quot3_q;
  logic signed [PW-1:0] prod2_q;

  // Stage 2/3 datapath
  logic signed [PW-1:0] diffw, dxw, gapw, prod_d;
  logic signed [W-1:0]  quot_d, f_d;

  assign diffw  = diff1_q;
  assign dxw    = dx1_q;
  assign prod_d = diffw * dxw;
  assign gapw   = gap2_q;
  assign quot_d = (gap2_q == '0) ? '0 : W'(prod2_q / gapw);
  assign f_d    = ramp3_q ? (mean3_q + quot3_q) : flat3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramp1_q <= 1'b0; ramp2_q <= 1'b0; ramp3_q <= 1'b0;
      flat1_q <= '0;   flat2_q <= '0;   flat3_q <= '0;
      mean1_q <= '0;   mean2_q <= '0;   mean3_q <= '0;
      gap1_q  <= '0;   gap2_q  <= '0;   diff1_q <= '0;
      dx1_q   <= '0;   prod2_q <= '0;   quot3_q <= '0;
      f_o     <= '0;
    end else begin
      ramp1_q <= ramp_d;  flat1_q <= flat_d; mean1_q <= mean_d;
      gap1_q  <= gap_d;   diff1_q <= diff_d; dx1_q   <= dx_d;
      ramp2_q <= ramp1_q; flat2_q <= flat1_q; mean2_q <= mean1_q;
      gap2_q  <= gap1_q;  prod2_q <= prod_d;
      ramp3_q <= ramp2_q; flat3_q <= flat2_q; mean3_q <= mean2_q;
      quot3_q <= quot_d;
      f_o     <= f_d;
    end
  end
endmodule

// File: rtl/sscroll_seq.sv
// Iteration sequencer: window counter, commit pulse and strobe.
module sscroll_seq
  import sscroll_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic commit_o,
  output logic step_o
);
  localparam int CW = $clog2(ITER_CLKS);
  localparam logic [CW-1:0] LAST = CW'(ITER_CLKS - 1);

  logic          run_q, run_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          step_d;

  assign commit_o = run_q && !start_i && (cnt_q == LAST);

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    step_d = commit_o;
    if (start_i) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (run_q) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      step_o <= 1'b0;
    end else begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      step_o <= step_d;
    end
  end
endmodule

// File: rtl/sscroll_gen.sv
// Forward Euler multi-scroll generator, saturated-series nonlinearity.
module sscroll_gen #(
  parameter int W    = 32,
  parameter int FRAC = 29,
  parameter int NLVL = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic signed [W-1:0]      x0_i,
  input  logic signed [W-1:0]      y0_i,
  input  logic signed [W-1:0]      z0_i,
  input  logic signed [W-1:0]      h_i,
  input  logic signed [W-1:0]      a_i,
  input  logic signed [W-1:0]      b_i,
  input  logic signed [W-1:0]      c_i,
  input  logic signed [W-1:0]      d1_i,
  input  logic [2*(NLVL-1)*W-1:0]  brk_i,
  input  logic [NLVL*W-1:0]        lvl_i,
  output logic signed [W-1:0]      x_o,
  output logic signed [W-1:0]      y_o,
  output logic signed [W-1:0]      z_o,
  output logic                     step_o
);
  logic commit;

  sscroll_seq seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .commit_o (commit),
    .step_o   (step_o)
  );

  // State registers
  logic signed [W-1:0] x_q, y_q, z_q, x_d, y_d, z_d;

  // Stage 1: h*y, h*z, a*x, b*y, c*z
  logic signed [W-1:0] hy_q, hz_q;
  logic signed [W-1:0] coef [3];
  logic signed [W-1:0] stv  [3];
  logic signed [W-1:0] lin1 [3];

  assign coef[0] = a_i;  assign stv[0] = x_q;
  assign coef[1] = b_i;  assign stv[1] = y_q;
  assign coef[2] = c_i;  assign stv[2] = z_q;

  for (genvar g = 0; g < 3; g++) begin : g_lin
    sscroll_mul #(.W(W), .FRAC(FRAC)) mul_i (
      .clk (clk), .rst_n (rst_n),
      .op_a (coef[g]), .op_b (stv[g]), .prod_o (lin1[g])
    );
  end

  sscroll_mul #(.W(W), .FRAC(FRAC)) mul_hy_i (
    .clk (clk), .rst_n (rst_n), .op_a (h_i), .op_b (y_q), .prod_o (hy_q)
  );
  sscroll_mul #(.W(W), .FRAC(FRAC)) mul_hz_i (
    .clk (clk), .rst_n (rst_n), .op_a (h_i), .op_b (z_q), .prod_o (hz_q)
  );

  // Stages 1-4: nonlinearity
  logic signed [W-1:0] f4;
  sscroll_pwl #(.W(W), .NLVL(NLVL)) pwl_i (
    .clk (clk), .rst_n (rst_n), .x_i (x_q),
    .brk_i (brk_i), .lvl_i (lvl_i), .f_o (f4)
  );

  // Stage 5: d1*f ; Stage 7: h*s
  logic signed [W-1:0] df5, s6_q, hs7;
  sscroll_mul #(.W(W), .FRAC(FRAC)) mul_df_i (
    .clk (clk), .rst_n (rst_n), .op_a (d1_i), .op_b (f4), .prod_o (df5)
  );
  sscroll_mul #(.W(W), .FRAC(FRAC)) mul_hs_i (
    .clk (clk), .rst_n (rst_n), .op_a (h_i), .op_b (s6_q), .prod_o (hs7)
  );

  // Linear sum alignment registers
  logic signed [W-1:0] pab2_q, cz2_q, lin3_q, lin4_q, lin5_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pab2_q <= '0; cz2_q <= '0; lin3_q <= '0;
      lin4_q <= '0; lin5_q <= '0; s6_q   <= '0;
    end else begin
      pab2_q <= lin1[0] + lin1[1];
      cz2_q  <= lin1[2];
      lin3_q <= pab2_q + cz2_q;
      lin4_q <= lin3_q;
      lin5_q <= lin4_q;
      s6_q   <= df5 - lin5_q;
    end
  end

  // Stage 8: commit adders into the state
  always_comb begin
    x_d = x_q;
    y_d = y_q;
    z_d = z_q;
    if (start_i) begin
      x_d = x0_i;
      y_d = y0_i;
      z_d = z0_i;
    end else if (commit) begin
      x_d = x_q + hy_q;
      y_d = y_q + hz_q;
      z_d = z_q + hs7;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
      z_q <= '0;
    end else begin
      x_q <= x_d;
      y_q <= y_d;
      z_q <= z_d;
    end
  end

  assign x_o = x_q;
  assign y_o = y_q;
  assign z_o = z_q;
endmodule

// File: rtl/sscroll_gen_chk.sv
module sscroll_gen_chk
  import sscroll_pkg::*;
#(
  parameter int W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic                step_o,
  input logic signed [W-1:0] x0_i,
  input logic signed [W-1:0] y0_i,
  input logic signed [W-1:0] z0_i,
  input logic signed [W-1:0] x_o,
  input logic signed [W-1:0] y_o,
  input logic signed [W-1:0] z_o
);
  localparam logic [7:0] WINC = 8'(ITER_CLKS);

  logic       armed_q;
  logic [7:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      gap_q   <= '0;
    end else if (start_i) begin
      armed_q <= 1'b1;
      gap_q   <= '0;
    end else if (step_o) begin
      gap_q   <= 8'd1;
    end else if (armed_q && gap_q != 8'hFF) begin
      gap_q   <= gap_q + 8'd1;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> !step_o);

  // R2
  init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (x_o == $past(x0_i)) && (y_o == $past(y0_i)) && (z_o == $past(z0_i)));

  // R3
  strobe_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && step_o |-> gap_q == WINC);

  // R3
  strobe_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && gap_q == WINC |-> step_o);

  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> !step_o);

  // R3
  state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i ##1 !step_o |-> $stable(x_o) && $stable(y_o) && $stable(z_o));
endmodule

bind sscroll_gen sscroll_gen_chk #(.W(W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .step_o  (step_o),
  .x0_i    (x0_i),
  .y0_i    (y0_i),
  .z0_i    (z0_i),
  .x_o     (x_o),
  .y_o     (y_o),
  .z_o     (z_o)
);

// File: tb/sscroll_gen_tb_top.sv
module sscroll_gen_tb_top;
  localparam int FRAC = 29;
  localparam int ONE  = 536870912;   // 1.0
  localparam int HALF = 268435456;   // 0.5
  localparam int BP   = 8858370;     // 0.0165
  localparam int K07  = 375809638;   // 0.7
  localparam int HSTP = 5368709;     // 0.01

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  int ix, iy, iz, hh, ca, cb, cc, cd;
  int bb [2];
  int kk [2];

  logic signed [31:0] x_o, y_o, z_o;
  logic step_o;

  sscroll_gen dut_i (
    .clk (clk), .rst_n (rst_n), .start_i (start),
    .x0_i (ix), .y0_i (iy), .z0_i (iz), .h_i (hh),
    .a_i (ca), .b_i (cb), .c_i (cc), .d1_i (cd),
    .brk_i ({bb[1], bb[0]}), .lvl_i ({kk[1], kk[0]}),
    .x_o (x_o), .y_o (y_o), .z_o (z_o), .step_o (step_o)
  );

  int nchk = 0;
  int nerr = 0;
  int mx, my, mz;

  task automatic check(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int fmul(int a, int b);
    return int'((longint'(a) * longint'(b)) >>> FRAC);
  endfunction

  function automatic int fpwl(int x);
    int f, mid, mean, gap, diff;
    longint p;
    f = kk[0];
    if (x >= bb[0]) f = kk[1];
    if (x >= bb[0] && x <= bb[1]) begin
      mid  = int'((longint'(bb[0]) + longint'(bb[1])) >>> 1);
      mean = int'((longint'(kk[0]) + longint'(kk[1])) >>> 1);
      gap  = bb[1] - bb[0];
      diff = kk[1] - kk[0];
      p    = longint'(diff) * longint'(x - mid);
      f    = mean + ((gap == 0) ? 0 : int'(p / longint'(gap)));
    end
    return f;
  endfunction

  task automatic model_step();
    int nx, ny, nz;
    nx = mx + fmul(hh, my);
    ny = my + fmul(hh, mz);
    nz = mz + fmul(hh, fmul(cd, fpwl(mx)) - (fmul(ca, mx) + fmul(cb, my) + fmul(cc, mz)));
    mx = nx; my = ny; mz = nz;
  endtask

  task automatic set_default();
    hh = HSTP; ca = K07; cb = K07; cc = K07; cd = K07;
    bb[0] = -BP; bb[1] = BP; kk[0] = -ONE; kk[1] = ONE;
  endtask

  // pulse start at a negedge; returns at the negedge after the load edge
  task automatic pulse_start(int x0, int y0, int z0);
    ix = x0; iy = y0; iz = z0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mx = x0; my = y0; mz = z0;
  endtask

  task automatic wait_step(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!step_o && n < 40);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    set_default();
    ix = 0; iy = 0; iz = 0;
    repeat (3) @(negedge clk);
    check("R1 reset x", x_o, 0);
    check("R1 reset z", z_o, 0);
    check("R1 reset strobe", int'(step_o), 0);
    rst_n = 1'b1;
    ix = ONE; iy = ONE; iz = ONE;
    begin
      int seen = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (step_o || x_o != 0) seen++;
      end
      check("R1 idle without start", seen, 0);
    end
  endtask

  task automatic t_default_run(int iters);
    int n, bad_gap;
    set_default();
    pulse_start(HALF / 5, 0, 0);
    check("R2 load x", x_o, HALF / 5);
    check("R2 load y", y_o, 0);
    bad_gap = 0;
    for (int i = 0; i < iters; i++) begin
      wait_step(n);
      if (n != 8) bad_gap++;
      model_step();
      check("R4 x update", x_o, mx);
      check("R5 y update", y_o, my);
      check("R6 z update", z_o, mz);
    end
    check("R3 strobe every 8 clocks", bad_gap, 0);
    @(negedge clk);
    check("R3 strobe one clock wide", int'(step_o), 0);
  endtask

  task automatic probe(string req, int xv, int exp_f);
    int n;
    hh = ONE; ca = 0; cb = 0; cc = 0; cd = ONE;
    pulse_start(xv, 0, 0);
    wait_step(n);
    check(req, z_o, exp_f);
    check("R4 x hold with y zero", x_o, xv);
  endtask

  task automatic t_pwl();
    set_default();
    probe("R7 below first breakpoint", -ONE, -ONE);
    probe("R7 one lsb below ramp", -BP - 1, -ONE);
    probe("R7 above last breakpoint", ONE, ONE);
    probe("R8 on lower breakpoint", -BP, fpwl(-BP));
    probe("R8 on upper breakpoint", BP, fpwl(BP));
    probe("R8 ramp midpoint", 0, 0);
    probe("R8 ramp interior", -BP / 2, fpwl(-BP / 2));
    probe("R8 ramp interior positive", 1234567, fpwl(1234567));
    bb[0] = 0; bb[1] = 0; kk[0] = -ONE; kk[1] = HALF;
    probe("R8 zero gap gives mean", 0, -134217728);
    probe("R7 above zero-gap ramp", 1, HALF);
  endtask

  task automatic t_trunc();
    int n;
    hh = HALF; ca = 0; cb = 0; cc = 0; cd = 0;
    pulse_start(1000, -1, 3);
    wait_step(n);
    check("R9 product floors toward minus infinity", x_o, 999);
    check("R9 positive product truncation", y_o, 0);
  endtask

  task automatic t_restart();
    int n;
    set_default();
    pulse_start(ONE / 3, 0, 0);
    repeat (3) @(negedge clk);
    check("R10 no strobe before restart", int'(step_o), 0);
    pulse_start(-ONE / 4, 1000, -2000);
    check("R10 restart reload x", x_o, -ONE / 4);
    check("R10 restart reload z", z_o, -2000);
    wait_step(n);
    check("R10 full window after restart", n, 8);
    model_step();
    check("R10 x after restart", x_o, mx);
    check("R10 y after restart", y_o, my);
    check("R10 z after restart", z_o, mz);
  endtask

  initial begin
    t_reset();
    t_default_run(300);
    t_pwl();
    t_trunc();
    t_restart();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule